// File: doc/BRIEF.md
# Mode-Register Write Timing Guard

This block sits between a memory controller's command scheduler and the command bus of a DDR3-class SDRAM. Commands arrive on a valid/ready request port. Each command is either a write to one of four mode registers or an ordinary command. The guard grants a command only when the device state and every post-write waiting period allow it. A granted command leaves on a registered command port one cycle later. The guard also keeps a shadow copy of all four mode registers.

A mode write starts several independent down-counters. Their lengths come from configuration inputs as cycle counts. One counter spaces mode writes from each other. One holds back all non-idle, non-mode commands. One holds back power-down entry. Two more extend the hold on non-mode commands, after a DLL reset and after a change of CAS latency. Back-pressure works in the usual way: `req_ready` is combinational, depends on the current `req_op`, and falls whenever that command would break a rule. A requester that sees `req_valid` high and `req_ready` low must hold the command and its fields stable until the handshake completes. A test-only `test_force` input overrides the stall. The command then goes through, and it is flagged on `cmd_err` if it broke a rule.

Top module: `mr_cmd_guard`

## Requirements
- R1: A granted mode write (opcode 2) stores all of `req_mr_data` into the shadow register chosen by `req_mr_sel`, which appears on `mr_shadow[sel*AW +: AW]` from the cycle after the grant. The other shadows are unchanged.
- R2: A mode write is stalled (`req_ready` low) while `bank_idle` is 0 or `burst_busy` is 1. It is granted in the cycle the condition clears.
- R3: If a mode write is granted at clock edge e, the next mode write is granted no earlier than edge e+max(tMRD,1).
- R4: Opcode encoding: NOP=0, deselect=1, mode write=2, ACT=3, RD=4, WR=5, PRE=6, power-down entry=7. NOP and deselect are always ready. Opcodes 3 to 7 are granted no earlier than edge e+max(tMOD,1) after a mode write granted at edge e.
- R5: Bit 8 of mode register 0 (DLL reset) is self-clearing, so the shadow stores it as 0. A mode-0 write with this bit set delays opcodes 3 to 7 until edge e+tDLL.
- R6: The CAS latency field of mode register 0 is made of bits 6:4 and bit 2. A mode-0 write that changes this field against the shadow delays opcodes 3 to 7 until edge e+tXPDLL. A mode-0 write that leaves the field unchanged adds no delay.
- R7: Power-down entry (opcode 7) is additionally held until edge e+tMRSPDEN after a mode write.
- R8: While `rst_n` is low, all shadows take their reset values (default 0) and `cmd_valid` is 0. Without a granted mode write, the shadows hold their values.
- R9: A grant (`req_valid` and `req_ready` high at an edge) yields `cmd_valid` for exactly one cycle after that edge, carrying that request's opcode, select and data. Without a grant, `cmd_valid` is 0.
- R10: With `test_force` high, a request is ready regardless of the rules. `cmd_err` is 1 alongside the output if the command broke a rule, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken this cycle |
| req_op | input | 3 | Request opcode |
| req_mr_sel | input | 2 | Mode register index for a mode write |
| req_mr_data | input | AW | Full mode register contents |
| bank_idle | input | 1 | All banks precharged and row-precharge time met |
| burst_busy | input | 1 | A data burst is in progress |
| test_force | input | 1 | Test override of the stall |
| cfg_t_mrd | input | CW | Mode-to-mode spacing in cycles |
| cfg_t_mod | input | CW | Mode-to-other-command delay in cycles |
| cfg_t_dll | input | CW | Hold after DLL reset in cycles |
| cfg_t_xpdll | input | CW | Hold after CAS latency change in cycles |
| cfg_t_mrspden | input | CW | Mode-to-power-down delay in cycles |
| cmd_valid | output | 1 | Registered command issued |
| cmd_op | output | 3 | Issued opcode |
| cmd_mr_sel | output | 2 | Issued mode register index |
| cmd_mr_data | output | AW | Issued address/data field |
| cmd_err | output | 1 | Issued command broke a rule (forced) |
| mr_shadow | output | 4*AW | Shadow copies, register i at bits i*AW +: AW |

## Verification
Each timing rule is tested by sending the follow-up command in the first cycle after a mode write, so the measured grant edge shows which counter held it. A read after a plain write, after a CAS latency change, after a DLL reset and after a repeat write with the same latency separates the four hold lengths 12, 20, 40 and 12. A read followed by a power-down entry separates the command hold from the power-down hold. The bank-idle and burst stalls are released at a known cycle, and forced commands inside and outside a hold show when the error flag fires and when it stays low.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_DES = 3'd1,
    OP_MRW = 3'd2,
    OP_ACT = 3'd3,
    OP_RD  = 3'd4,
    OP_WR  = 3'd5,
    OP_PRE = 3'd6,
    OP_PDE = 3'd7
  } op_e;

  localparam int NUM_MR   = 4;
  localparam int NUM_HOLD = 5;

  // hold-off counter slots
  localparam int H_MRD = 0;  // mode write to mode write
  localparam int H_MOD = 1;  // mode write to other command
  localparam int H_DLL = 2;  // DLL reset extension
  localparam int H_CLX = 3;  // CAS latency change extension
  localparam int H_PDN = 4;  // mode write to power-down entry

  function automatic logic op_is_idle(op_e o);
    return (o == OP_NOP) || (o == OP_DES);
  endfunction

endpackage

// File: rtl/mrg_holdoff.sv
module mrg_holdoff #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] span,
  output logic          busy
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] start_val;

  // a span of N cycles: grant allowed N edges after the loading edge
  assign start_val = (span == '0) ? '0 : span - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= start_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  p_hold_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_hold_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(start_val)));

  p_hold_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/mrg_shadow.sv
module mrg_shadow
  import mrg_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [NUM_MR*AW-1:0] RESET_VAL = '0,
  parameter int DLL_BIT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [1:0]             sel,
  input  logic [AW-1:0]          data,
  output logic                   dll_hit,
  output logic                   cl_change,
  output logic [NUM_MR*AW-1:0]   shadow
);
  logic [AW-1:0] regs_q [NUM_MR];
  logic [3:0]    cl_new, cl_old;

  for (genvar i = 0; i < NUM_MR; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= RESET_VAL[i*AW +: AW];
      end else if (wr && sel == 2'(i)) begin
        if (i == 0) begin
          regs_q[i]          <= data;
          regs_q[i][DLL_BIT] <= 1'b0;
        end else begin
          regs_q[i] <= data;
        end
      end
    end
    assign shadow[i*AW +: AW] = regs_q[i];
  end

  // latency field of register 0: bits 6:4 plus bit 2
  assign cl_new    = {data[6:4], data[2]};
  assign cl_old    = {regs_q[0][6:4], regs_q[0][2]};
  assign cl_change = (sel == 2'd0) && (cl_new != cl_old);
  assign dll_hit   = (sel == 2'd0) && data[DLL_BIT];

  p_dll_selfclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == 2'd0) |=> (shadow[DLL_BIT] == 1'b0));

  p_shadow_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(shadow));

endmodule

// File: rtl/mrg_rules.sv
module mrg_rules
  import mrg_pkg::*;
(
  input  op_e                 op,
  input  logic                bank_idle,
  input  logic                burst_busy,
  input  logic [NUM_HOLD-1:0] hold_busy,
  output logic                legal
);
  logic cmd_clear;

  assign cmd_clear = !hold_busy[H_MOD] && !hold_busy[H_DLL] && !hold_busy[H_CLX];

  always_comb begin
    unique case (op)
      OP_NOP, OP_DES: legal = 1'b1;
      OP_MRW:         legal = bank_idle && !burst_busy && !hold_busy[H_MRD];
      OP_PDE:         legal = cmd_clear && !hold_busy[H_PDN];
      default:        legal = cmd_clear;
    endcase
  end

endmodule

// File: rtl/mr_cmd_guard.sv
module mr_cmd_guard
  import mrg_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter logic [4*AW-1:0] MR_RESET = '0,
  parameter int DLL_BIT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [1:0]      req_mr_sel,
  input  logic [AW-1:0]   req_mr_data,
  input  logic            bank_idle,
  input  logic            burst_busy,
  input  logic            test_force,
  input  logic [CW-1:0]   cfg_t_mrd,
  input  logic [CW-1:0]   cfg_t_mod,
  input  logic [CW-1:0]   cfg_t_dll,
  input  logic [CW-1:0]   cfg_t_xpdll,
  input  logic [CW-1:0]   cfg_t_mrspden,
  output logic            cmd_valid,
  output logic [2:0]      cmd_op,
  output logic [1:0]      cmd_mr_sel,
  output logic [AW-1:0]   cmd_mr_data,
  output logic            cmd_err,
  output logic [4*AW-1:0] mr_shadow
);
  op_e                 op;
  logic                legal, fire, mr_fire;
  logic                dll_hit, cl_change;
  logic [NUM_HOLD-1:0] hold_busy, hold_load;
  logic [CW-1:0]       hold_span [NUM_HOLD];

  assign op        = op_e'(req_op);
  assign req_ready = legal || test_force;
  assign fire      = req_valid && req_ready;
  assign mr_fire   = fire && (op == OP_MRW);

  mrg_rules u_rules (
    .op         (op),
    .bank_idle  (bank_idle),
    .burst_busy (burst_busy),
    .hold_busy  (hold_busy),
    .legal      (legal)
  );

  mrg_shadow #(.AW(AW), .RESET_VAL(MR_RESET), .DLL_BIT(DLL_BIT)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (mr_fire),
    .sel       (req_mr_sel),
    .data      (req_mr_data),
    .dll_hit   (dll_hit),
    .cl_change (cl_change),
    .shadow    (mr_shadow)
  );

  assign hold_span[H_MRD] = cfg_t_mrd;
  assign hold_span[H_MOD] = cfg_t_mod;
  assign hold_span[H_DLL] = cfg_t_dll;
  assign hold_span[H_CLX] = cfg_t_xpdll;
  assign hold_span[H_PDN] = cfg_t_mrspden;

  assign hold_load[H_MRD] = mr_fire;
  assign hold_load[H_MOD] = mr_fire;
  assign hold_load[H_DLL] = mr_fire && dll_hit;
  assign hold_load[H_CLX] = mr_fire && cl_change;
  assign hold_load[H_PDN] = mr_fire;

  for (genvar h = 0; h < NUM_HOLD; h++) begin : g_hold
    mrg_holdoff #(.CW(CW)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hold_load[h]),
      .span  (hold_span[h]),
      .busy  (hold_busy[h])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_op      <= OP_NOP;
      cmd_mr_sel  <= '0;
      cmd_mr_data <= '0;
      cmd_err     <= 1'b0;
    end else begin
      cmd_valid <= fire;
      cmd_err   <= fire && !legal;
      if (fire) begin
        cmd_op      <= req_op;
        cmd_mr_sel  <= req_mr_sel;
        cmd_mr_data <= req_mr_data;
      end
    end
  end

  p_idle_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_is_idle(op)) |-> req_ready);

  p_mrw_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_MRW && hold_busy[H_MRD] && !test_force) |-> !req_ready);

  p_mrw_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_MRW && (!bank_idle || burst_busy) && !test_force) |-> !req_ready);

  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !op_is_idle(op) && op != OP_MRW && hold_busy[H_MOD] && !test_force)
      |-> !req_ready);

  p_pdn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op == OP_PDE && hold_busy[H_PDN] && !test_force) |-> !req_ready);

  p_out_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmd_valid);

  p_out_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !cmd_valid);

  p_err_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (cmd_valid && $past(test_force)));

endmodule

// File: tb/tb_mr_cmd_guard.sv
`timescale 1ns/1ps
module tb_mr_cmd_guard;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int T_MRD = 4, T_MOD = 12, T_DLL = 40, T_XP = 20, T_SPD = 16;

  typedef struct packed {
    logic [2:0]    op;
    logic [1:0]    sel;
    logic [AW-1:0] data;
    logic          err;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [2:0] req_op = 0;
  logic [1:0] req_mr_sel = 0;
  logic [AW-1:0] req_mr_data = 0;
  logic bank_idle = 1, burst_busy = 0, test_force = 0;
  logic [CW-1:0] cfg_t_mrd = T_MRD, cfg_t_mod = T_MOD, cfg_t_dll = T_DLL;
  logic [CW-1:0] cfg_t_xpdll = T_XP, cfg_t_mrspden = T_SPD;
  logic cmd_valid, cmd_err;
  logic [2:0] cmd_op;
  logic [1:0] cmd_mr_sel;
  logic [AW-1:0] cmd_mr_data;
  logic [4*AW-1:0] mr_shadow;

  int checks = 0, errors = 0, cyc = 0;
  exp_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mr_cmd_guard #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mr_sel(req_mr_sel), .req_mr_data(req_mr_data),
    .bank_idle(bank_idle), .burst_busy(burst_busy), .test_force(test_force),
    .cfg_t_mrd(cfg_t_mrd), .cfg_t_mod(cfg_t_mod), .cfg_t_dll(cfg_t_dll),
    .cfg_t_xpdll(cfg_t_xpdll), .cfg_t_mrspden(cfg_t_mrspden),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mr_sel(cmd_mr_sel),
    .cmd_mr_data(cmd_mr_data), .cmd_err(cmd_err), .mr_shadow(mr_shadow)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor (R9, R10)
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R9", "unexpected cmd_valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R9", "cmd_op", cmd_op, e.op);
        chk("R9", "cmd_mr_sel", cmd_mr_sel, e.sel);
        chk("R9", "cmd_mr_data", cmd_mr_data, e.data);
        chk("R10", "cmd_err", cmd_err, e.err);
      end
    end
  end

  // driver: returns the clock edge at which the request was granted
  task automatic send(input logic [2:0] op, input logic [1:0] sel, input logic [AW-1:0] d,
                      input logic frc, input logic exp_err, output int ge);
    exp_t it;
    @(negedge clk);
    req_valid = 1; req_op = op; req_mr_sel = sel; req_mr_data = d; test_force = frc;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    ge = cyc + 1;
    it.op = op; it.sel = sel; it.data = d; it.err = exp_err;
    exp_q.push_back(it);
    @(posedge clk);
    #1;
    req_valid = 0; test_force = 0; req_op = 3'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e, g, rel;
    repeat (3) @(negedge clk);
    chk("R8", "shadow at reset", mr_shadow, 0);
    chk("R8", "cmd_valid at reset", cmd_valid, 0);
    rst_n = 1;
    idle(2);

    // R3 spacing, R4 NOP pass and command hold
    send(3'd2, 2'd1, 16'h0044, 0, 0, e);
    send(3'd2, 2'd2, 16'h0008, 0, 0, g);
    chk("R3", "mode-to-mode edge", g, e + T_MRD);
    e = g;
    send(3'd0, 2'd0, 16'h0000, 0, 0, g);
    chk("R4", "NOP edge", g, e + 1);
    send(3'd4, 2'd0, 16'h0100, 0, 0, g);
    chk("R4", "RD after mode write", g, e + T_MOD);
    chk("R1", "shadow 1", mr_shadow[1*AW +: AW], 16'h0044);
    chk("R1", "shadow 2", mr_shadow[2*AW +: AW], 16'h0008);

    // R6 CAS latency change
    idle(60);
    send(3'd2, 2'd0, 16'h0020, 0, 0, e);
    send(3'd4, 2'd0, 16'h0000, 0, 0, g);
    chk("R6", "RD after CL change", g, e + T_XP);

    // R5 DLL reset
    idle(60);
    send(3'd2, 2'd0, 16'h0120, 0, 0, e);
    send(3'd3, 2'd0, 16'h0000, 0, 0, g);
    chk("R5", "ACT after DLL reset", g, e + T_DLL);
    chk("R5", "DLL bit cleared in shadow 0", mr_shadow[0 +: AW], 16'h0020);

    // R6 same latency: only the plain hold
    idle(60);
    send(3'd2, 2'd0, 16'h0020, 0, 0, e);
    send(3'd5, 2'd0, 16'h0000, 0, 0, g);
    chk("R6", "WR with unchanged CL", g, e + T_MOD);

    // R7 power-down hold
    idle(60);
    send(3'd2, 2'd3, 16'h0600, 0, 0, e);
    send(3'd6, 2'd0, 16'h0000, 0, 0, g);
    chk("R4", "PRE after mode write", g, e + T_MOD);
    send(3'd7, 2'd0, 16'h0000, 0, 0, g);
    chk("R7", "PDE after mode write", g, e + T_SPD);

    // R2 bank and burst state
    idle(60);
    bank_idle = 0;
    fork
      send(3'd2, 2'd1, 16'h0011, 0, 0, g);
      begin idle(5); rel = cyc; bank_idle = 1; end
    join
    chk("R2", "grant after banks idle", g, rel + 1);
    idle(60);
    burst_busy = 1;
    fork
      send(3'd2, 2'd2, 16'h0022, 0, 0, g);
      begin idle(7); rel = cyc; burst_busy = 0; end
    join
    chk("R2", "grant after burst end", g, rel + 1);

    // R10 forced commands
    idle(60);
    send(3'd2, 2'd3, 16'h0033, 0, 0, e);
    send(3'd4, 2'd0, 16'h0000, 1, 1, g);
    chk("R10", "forced RD edge", g, e + 1);
    send(3'd0, 2'd0, 16'h0000, 1, 0, g);
    send(3'd2, 2'd3, 16'h0077, 1, 1, g);
    chk("R10", "forced MRW edge", g, e + 3);

    // R1 full shadow contents
    idle(60);
    chk("R1", "shadow 0", mr_shadow[0*AW +: AW], 16'h0020);
    chk("R1", "shadow 1", mr_shadow[1*AW +: AW], 16'h0011);
    chk("R1", "shadow 2", mr_shadow[2*AW +: AW], 16'h0022);
    chk("R1", "shadow 3", mr_shadow[3*AW +: AW], 16'h0077);

    // R8 reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R8", "shadow after reset", mr_shadow, 0);
    chk("R8", "cmd_valid after reset", cmd_valid, 0);
    idle(2);
    rst_n = 1;
    idle(4);
    chk("R9", "scoreboard drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule